// File: doc/BRIEF.md
# Mode-Configurable Bidirectional Bus Transceiver

This block moves a data word between two sides of a board-level interface. Side A has a dedicated input word and a dedicated output word. Side B is one shared bus that can only pull its lines low or release them. The bus is modelled as open-drain: the block reports on `b_pull` which lines it pulls low, and it reads the resolved line levels back on `b_line`. The pull-up and any other drivers on that bus lie outside the block.

Each direction has its own storage element and its own 2-bit mode code. The code makes that element a transparent buffer, an edge-triggered register or a level-sensitive latch. A single control pin per direction serves as the clock in register mode and as the enable in latch mode. The control pins are sampled by the system clock `clk`. The data is inverted on its way through in every mode. A loopback control makes the B-to-A path read side A's input word instead of the B bus, so side A can be tested without the B bus. A synchronous reset clears both storage elements, which leaves side B released and side A driving ones.

Top module: `bus_xcvr`

## Requirements
- R1: With a mode code of 00 or 11 (buffer), the destination word equals the bitwise inverse of the source word in the same cycle, with no clock involved. This holds in each direction.
- R2: With mode code 01 (register), the element captures its source at the first `clk` edge at which the control pin is sampled high after having been sampled low. From the following cycle the output is the inverse of the captured word. The value does not change at any other edge.
- R3: With mode code 10 (latch), the output follows the inverse of the source combinationally while the control pin is high. While the pin is low, the output holds the inverse of the source as sampled at the last `clk` edge at which the pin was high.
- R4: The A-to-B direction (`mode_ab`, `ctl_ab`) and the B-to-A direction (`mode_ba`, `ctl_ba`) operate independently. Any mix of modes can be used.
- R5: Side B is open-drain. `b_pull[i]` is 1, meaning line i is pulled low, exactly when B driving is enabled and the A-to-B output bit i is 0. A 1 bit in the output releases the line.
- R6: B driving is enabled only when `b_oe` = 1 and `b_oe_n` = 0. Otherwise `b_pull` is all zeros.
- R7: When `a_oe` = 0, `a_out` is all zeros. When `a_oe` = 1, `a_out` carries the B-to-A output word.
- R8: With `loopback` = 1, the B-to-A path takes `a_in` as its source. With `loopback` = 0, it takes `b_line` as its source.
- R9: Synchronous reset clears both stored words to zero. After reset, a register-mode direction therefore releases all B lines and drives `a_out` to all ones when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the control pins |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Side A input word |
| a_out | output | WIDTH | Side A output word (zero when disabled) |
| a_oe | input | 1 | Side A output enable |
| b_line | input | WIDTH | Resolved level of the shared B bus |
| b_pull | output | WIDTH | 1 = pull the B line low |
| b_oe | input | 1 | Active-high B enable |
| b_oe_n | input | 1 | Active-low B enable |
| mode_ab | input | 2 | A-to-B mode: 00/11 buffer, 01 register, 10 latch |
| mode_ba | input | 2 | B-to-A mode, same encoding |
| ctl_ab | input | 1 | A-to-B clock / latch enable |
| ctl_ba | input | 1 | B-to-A clock / latch enable |
| loopback | input | 1 | 1 = B-to-A path sources from `a_in` |

## Verification
A corrupted stored word stays hidden in buffer mode. It reaches the ports only in register mode, or in latch mode with the enable low. It then appears on `b_pull` or `a_out` in the first cycle after the bad capture. A wrong edge detector on a control pin shows up as a capture one cycle late, or as a capture while the pin stays high. The bench detects this by checking the outputs on every cycle of slowly toggling control patterns. Enable and loopback faults are combinational, so they appear in the same cycle as the stimulus that exposes them.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
   typedef enum logic [1:0] {
      XM_BUF   = 2'b00,
      XM_REG   = 2'b01,
      XM_LATCH = 2'b10,
      XM_BUF_B = 2'b11
   } xfer_mode_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
   import bus_xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode,
   input  logic             ctl,
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] dst
);
   localparam logic [WIDTH-1:0] CLEAR = '0;

   xfer_mode_t       mode_e;
   logic             ctl_q;
   logic             ctl_rise;
   logic [WIDTH-1:0] held;
   logic [WIDTH-1:0] pick;

   assign mode_e   = xfer_mode_t'(mode);
   assign ctl_rise = ctl & ~ctl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         held  <= CLEAR;
         ctl_q <= 1'b0;
      end else begin
         ctl_q <= ctl;
         case (mode_e)
            XM_REG:   if (ctl_rise) held <= src;
            XM_LATCH: if (ctl) held <= src;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (mode_e)
         XM_REG:   pick = held;
         XM_LATCH: pick = ctl ? src : held;
         default:  pick = src;
      endcase
   end

   assign dst = ~pick;

   // R2: no capture without a sampled rising control edge
   p_reg_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_e == XM_REG && !ctl_rise) |=> $stable(held));
   // R2: capture on the rising edge
   p_reg_capture_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_e == XM_REG && ctl_rise) |=> held == $past(src));
   // R3: latch tracks source while enabled
   p_latch_follow_r3: assert property (@(posedge clk) disable iff (rst)
      (mode_e == XM_LATCH && ctl) |=> held == $past(src));
   // R3: latch holds while disabled
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (mode_e == XM_LATCH && !ctl) |=> $stable(held));
endmodule

// File: rtl/xcvr_od_drv.sv
module xcvr_od_drv #(
   parameter int WIDTH = 8
) (
   input  logic             en_hi,
   input  logic             en_lo_n,
   input  logic [WIDTH-1:0] val,
   output logic [WIDTH-1:0] pull
);
   logic drive;
   assign drive = en_hi & ~en_lo_n;

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      assign pull[i] = drive & ~val[i];
   end
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
   import bus_xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   input  logic             a_oe,
   input  logic [WIDTH-1:0] b_line,
   output logic [WIDTH-1:0] b_pull,
   input  logic             b_oe,
   input  logic             b_oe_n,
   input  logic [1:0]       mode_ab,
   input  logic [1:0]       mode_ba,
   input  logic             ctl_ab,
   input  logic             ctl_ba,
   input  logic             loopback
);
   localparam logic [WIDTH-1:0] IDLE_A = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("bus_xcvr: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] ab_val;
   logic [WIDTH-1:0] ba_src;
   logic [WIDTH-1:0] ba_val;

   xcvr_store #(.WIDTH(WIDTH)) u_ab (
      .clk (clk), .rst (rst), .mode (mode_ab), .ctl (ctl_ab),
      .src (a_in), .dst (ab_val)
   );

   assign ba_src = loopback ? a_in : b_line;

   xcvr_store #(.WIDTH(WIDTH)) u_ba (
      .clk (clk), .rst (rst), .mode (mode_ba), .ctl (ctl_ba),
      .src (ba_src), .dst (ba_val)
   );

   xcvr_od_drv #(.WIDTH(WIDTH)) u_bdrv (
      .en_hi (b_oe), .en_lo_n (b_oe_n), .val (ab_val), .pull (b_pull)
   );

   assign a_out = a_oe ? ba_val : IDLE_A;

   // R6: B bus untouched unless both enables agree
   p_b_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !(b_oe && !b_oe_n) |-> b_pull == '0);
   // R8: loopback buffer path returns inverted A input
   p_loop_buf_r8: assert property (@(posedge clk) disable iff (rst)
      (a_oe && loopback && (mode_ba == 2'b00 || mode_ba == 2'b11)) |-> a_out == ~a_in);
endmodule

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] a_in = '0, ext_b = 8'hFF;
   logic       a_oe = 1'b1, b_oe = 1'b1, b_oe_n = 1'b0, loopback = 1'b0;
   logic [1:0] mode_ab = 2'b01, mode_ba = 2'b01;
   logic       ctl_ab = 1'b0, ctl_ba = 1'b0;
   logic [7:0] a_out, b_pull, b_line;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   // pull-up plus other open-drain drivers on the B bus
   assign b_line = ~b_pull & ext_b;

   bus_xcvr #(.WIDTH(8)) dut (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_line(b_line), .b_pull(b_pull), .b_oe(b_oe), .b_oe_n(b_oe_n),
      .mode_ab(mode_ab), .mode_ba(mode_ba), .ctl_ab(ctl_ab), .ctl_ba(ctl_ba),
      .loopback(loopback)
   );

   // reference state
   logic [7:0] m_hab = '0, m_hba = '0;
   bit m_pab = 0, m_pba = 0;

   function automatic logic [7:0] seen(logic [1:0] m, logic c, logic [7:0] s, logic [7:0] h);
      if (m == 2'b01) return h;
      if (m == 2'b10) return c ? s : h;
      return s;
   endfunction

   function automatic logic [7:0] exp_pull();
      return (b_oe && !b_oe_n) ? seen(mode_ab, ctl_ab, a_in, m_hab) : 8'h00;
   endfunction

   function automatic logic [7:0] exp_ba_src();
      return loopback ? a_in : (~exp_pull() & ext_b);
   endfunction

   function automatic logic [7:0] exp_aout();
      return a_oe ? ~seen(mode_ba, ctl_ba, exp_ba_src(), m_hba) : 8'h00;
   endfunction

   always @(posedge clk) begin
      logic [7:0] sba;
      sba = exp_ba_src();
      if (rst) begin
         m_hab = '0; m_hba = '0; m_pab = 0; m_pba = 0;
      end else begin
         if ((mode_ab == 2'b01 && ctl_ab && !m_pab) || (mode_ab == 2'b10 && ctl_ab)) m_hab = a_in;
         if ((mode_ba == 2'b01 && ctl_ba && !m_pba) || (mode_ba == 2'b10 && ctl_ba)) m_hba = sba;
         m_pab = ctl_ab; m_pba = ctl_ba;
      end
   end

   task automatic check(string tag);
      logic [7:0] ep, ea;
      ep = exp_pull(); ea = exp_aout();
      checks++;
      if (b_pull !== ep) begin
         fails++;
         $display("FAIL %s b_pull actual %h expected %h", tag, b_pull, ep);
      end
      checks++;
      if (a_out !== ea) begin
         fails++;
         $display("FAIL %s a_out actual %h expected %h", tag, a_out, ea);
      end
   endtask

   task automatic run(string tag, int n, logic [1:0] mab, logic [1:0] mba,
                      bit rnd_en, bit rnd_lp, bit rnd_ext, int ctl_div);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         a_in = 8'($urandom);
         mode_ab = mab; mode_ba = mba;
         ext_b = rnd_ext ? 8'($urandom) : 8'hFF;
         if (rnd_en) begin
            a_oe = 1'($urandom); b_oe = 1'($urandom); b_oe_n = 1'($urandom);
         end else begin
            a_oe = 1'b1; b_oe = 1'b1; b_oe_n = 1'b0;
         end
         loopback = rnd_lp ? 1'($urandom) : 1'b0;
         if ($urandom % ctl_div == 0) ctl_ab = ~ctl_ab;
         if ($urandom % ctl_div == 0) ctl_ba = ~ctl_ba;
         #1 check(tag);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1 check("R9 reset state");
      if (b_pull !== 8'h00 || a_out !== 8'hFF) begin
         checks++; fails++;
         $display("FAIL R9 post-reset actual %h/%h expected 00/ff", b_pull, a_out);
      end else checks++;
      run("R1 buffer 00", 40, 2'b00, 2'b00, 0, 0, 1, 2);
      run("R1 buffer 11", 40, 2'b11, 2'b11, 0, 0, 1, 2);
      run("R2 register", 200, 2'b01, 2'b01, 0, 0, 1, 3);
      run("R3 latch", 200, 2'b10, 2'b10, 0, 0, 1, 4);
      run("R4 reg/latch mix", 150, 2'b01, 2'b10, 0, 1, 1, 3);
      run("R4 buf/reg mix", 150, 2'b11, 2'b01, 0, 1, 1, 3);
      run("R5 open-drain contention", 100, 2'b00, 2'b00, 0, 0, 1, 2);
      run("R6 R7 enables", 200, 2'b00, 2'b01, 1, 0, 1, 3);
      run("R8 loopback", 150, 2'b10, 2'b00, 1, 1, 0, 3);
      @(negedge clk); rst = 1'b1; mode_ab = 2'b01; mode_ba = 2'b01;
      ctl_ab = 1'b0; ctl_ba = 1'b0; a_oe = 1'b1; b_oe = 1'b1; b_oe_n = 1'b0;
      @(negedge clk); rst = 1'b0;
      #1 check("R9 second reset");
      run("R2 R3 after reset", 100, 2'b10, 2'b01, 1, 1, 1, 3);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule